// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block guards a system against software that stops running. Once software turns it on, a counter advances on every system clock. Software restarts the counter by writing a restart strobe. If the counter reaches the selected interval without a restart, the block sets a sticky timeout flag. The interrupt output then rises, provided the interrupt enable is set. A fixed 512 clocks after that warning, the block issues a one-cycle system reset request, provided the reset enable is set. This gives the interrupt handler a bounded window in which to put the system in a safe state, or to restart the counter and cancel the reset.

Software reaches the block through a single 8-bit control register. A write takes effect on the clock edge where `wr_en` is high. The read port always shows the current register contents. Four interval codes are available. A change of code restarts the count, so switching intervals cannot cause an early expiry. After a reset pulse, or after a warning window that ends without one, counting starts again from zero.

Top module: `wdog_top`

## Requirements
- R1: After reset, the read data is 0x00 and both `irq` and `rst_req` are low.
- R2: The control register layout is: bit 0 = run, bits 2:1 = interval code, bit 3 = interrupt enable, bit 4 = reset enable, bit 5 = timeout flag, bit 6 = restart strobe (always reads 0), bit 7 (always reads 0).
- R3: Interval codes 0, 1, 2 and 3 select 2^12, 2^15, 2^18 and 2^21 clocks. The flag sets exactly that many clock edges after the write edge that restarted the count, and not earlier.
- R4: The timeout flag stays set until a write with bit 5 at 0 clears it. A write with bit 5 at 1 leaves the flag unchanged and never sets it. If an expiry and a clearing write fall on the same edge, the flag ends up set.
- R5: `irq` is high exactly when the timeout flag and the interrupt enable are both set.
- R6: With reset enable set, `rst_req` is high for exactly one cycle. That cycle is 512 clock edges after the edge that set the flag. Clearing the flag inside the window does not stop the reset.
- R7: A write with bit 6 at 1 clears the counter and cancels any warning window in progress, so no `rst_req` follows from that expiry. It does not clear the flag.
- R8: A write that changes the interval code restarts the count from zero.
- R9: While run is 0, the counter is held at zero and no flag or reset request is produced. Setting run starts a full interval from the write edge.
- R10: After the warning window ends, counting restarts from zero. With no service, reset requests repeat every interval plus 512 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Value written to the control register |
| rd_data | output | 8 | Current control register contents |
| irq | output | 1 | Early-warning interrupt (flag gated by interrupt enable) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The expiry path is driven through a table of configurations. The table pairs different interval codes with the interrupt enable on and off, so the bench can tell a wrong interval decode apart from a wrong interrupt gate. Directed tests then probe the edges of the warning window:
- a flag clear inside the window, which must not stop the reset;
- a restart inside the window, which must stop it;
- an interval change part-way through a count, which must start a full new interval rather than letting the old count expire early;
- dropping the run bit, which must leave the block silent and give a full interval once it runs again.

Repeated reset pulses with no service show that counting wraps back to zero after each window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTRL_W   = 8;
  localparam int BIT_RUN  = 0;
  localparam int BIT_SEL  = 1;
  localparam int SEL_W    = 2;
  localparam int BIT_IEN  = 3;
  localparam int BIT_REN  = 4;
  localparam int BIT_FLAG = 5;
  localparam int BIT_KICK = 6;
  localparam int N_SEL    = 1 << SEL_W;

  typedef enum logic {
    PH_COUNT = 1'b0,
    PH_WARN  = 1'b1
  } wdog_phase_e;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTRL_W-1:0]    wr_data,
  input  logic                 expire,
  output logic                 run,
  output logic [SEL_W-1:0]     sel,
  output logic                 ien,
  output logic                 ren,
  output logic                 flag,
  output logic                 kick,
  output logic                 sel_chg,
  output logic [CTRL_W-1:0]    rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      sel  <= '0;
      ien  <= 1'b0;
      ren  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_en) begin
        run <= wr_data[BIT_RUN];
        sel <= wr_data[BIT_SEL +: SEL_W];
        ien <= wr_data[BIT_IEN];
        ren <= wr_data[BIT_REN];
      end
      // a new expiry wins over a clearing write on the same edge
      if (expire)
        flag <= 1'b1;
      else if (wr_en && !wr_data[BIT_FLAG])
        flag <= 1'b0;
    end
  end

  assign kick    = wr_en & wr_data[BIT_KICK];
  assign sel_chg = wr_en & (wr_data[BIT_SEL +: SEL_W] != sel);

  always_comb begin
    rd_data                      = '0;
    rd_data[BIT_RUN]             = run;
    rd_data[BIT_SEL +: SEL_W]    = sel;
    rd_data[BIT_IEN]             = ien;
    rd_data[BIT_REN]             = ren;
    rd_data[BIT_FLAG]            = flag;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && !wr_data[BIT_FLAG])) |=> flag); // R4
  AST_FLAG_ONLY_BY_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !expire) |=> !flag); // R4
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
#(
  parameter int EXP0 = 12,
  parameter int EXP1 = 15,
  parameter int EXP2 = 18,
  parameter int EXP3 = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             count_en,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int CNT_W = EXP3;
  localparam int EXPS [N_SEL] = '{EXP0, EXP1, EXP2, EXP3};

  logic [CNT_W-1:0] cnt;
  logic [N_SEL-1:0] hit;

  for (genvar g = 0; g < N_SEL; g++) begin : g_limit
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'((64'd1 << EXPS[g]) - 64'd1);
    assign hit[g] = (cnt == LIMIT);
  end

  assign expire = count_en & ~clr & hit[sel];

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (count_en) begin
      if (expire)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R7
  AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clr) |=> $stable(cnt)); // R9
endmodule

// File: rtl/wdog_warn.sv
module wdog_warn
  import wdog_pkg::*;
#(
  parameter int WARN_CLKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic run,
  input  logic kick,
  input  logic expire,
  input  logic ren,
  output logic in_warn,
  output logic rst_req
);
  localparam int WIN_W = $clog2(WARN_CLKS);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WARN_CLKS - 1);

  wdog_phase_e      phase;
  logic [WIN_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_COUNT;
      wcnt    <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (abort) begin
        phase <= PH_COUNT;
        wcnt  <= '0;
      end else begin
        unique case (phase)
          PH_COUNT: begin
            if (expire) begin
              phase <= PH_WARN;
              wcnt  <= '0;
            end
          end
          PH_WARN: begin
            if (wcnt == WIN_LAST) begin
              phase   <= PH_COUNT;
              wcnt    <= '0;
              rst_req <= ren;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          default: phase <= PH_COUNT;
        endcase
      end
    end
  end

  assign in_warn = (phase == PH_WARN);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_RST_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(phase) == PH_WARN)); // R6
  AST_KICK_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (phase == PH_COUNT && !rst_req)); // R7
  AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!rst_req && phase == PH_COUNT)); // R9
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int EXP0      = 12,
  parameter int EXP1      = 15,
  parameter int EXP2      = 18,
  parameter int EXP3      = 21,
  parameter int WARN_CLKS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq,
  output logic              rst_req
);
  logic             run, ien, ren, flag, kick, sel_chg;
  logic [SEL_W-1:0] sel;
  logic             expire, in_warn, abort, clr, count_en;

  wdog_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .expire  (expire),
    .run     (run),
    .sel     (sel),
    .ien     (ien),
    .ren     (ren),
    .flag    (flag),
    .kick    (kick),
    .sel_chg (sel_chg),
    .rd_data (rd_data)
  );

  assign abort    = ~run | kick | sel_chg;
  assign clr      = abort;
  assign count_en = run & ~in_warn;

  wdog_interval #(
    .EXP0 (EXP0),
    .EXP1 (EXP1),
    .EXP2 (EXP2),
    .EXP3 (EXP3)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .count_en (count_en),
    .sel      (sel),
    .expire   (expire)
  );

  wdog_warn #(
    .WARN_CLKS (WARN_CLKS)
  ) u_warn (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .run     (run),
    .kick    (kick),
    .expire  (expire),
    .ren     (ren),
    .in_warn (in_warn),
    .rst_req (rst_req)
  );

  assign irq = flag & ien;

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) || $past(wr_en))); // R5
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en)); // R5
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int rel = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wdog_top i_wdog_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq),
    .rst_req (rst_req)
  );

  localparam int N_VEC = 3;
  localparam logic [7:0] VEC_CFG [N_VEC] = '{8'h01, 8'h0B, 8'h09};
  localparam int         VEC_LEN [N_VEC] = '{4096, 32768, 4096};
  localparam logic       VEC_IRQ [N_VEC] = '{1'b0, 1'b1, 1'b1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (rel %0d)", req, act, exp, rel);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rel++;
  endtask

  task automatic wait_until(input int k);
    while (rel < k) begin
      @(posedge clk);
      #1;
      rel++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rst_req", rst_req, 1'b0);

    // R2 layout: bits 7 and 6 read 0; R4 writing flag=1 does not set it
    wr(8'hDE);
    chk("R2 readback", rd_data, 8'h1E);
    wr(8'h3E);
    chk("R4 write-one no set", rd_data, 8'h1E);
    wr(8'h00);

    // R3/R5 table of configurations
    for (int i = 0; i < N_VEC; i++) begin
      wr(8'h00);
      wr(VEC_CFG[i]);
      rel = 0;
      wait_until(VEC_LEN[i] - 1);
      chk("R3 no early flag", rd_data[5], 1'b0);
      wait_until(VEC_LEN[i]);
      chk("R3 flag at interval", rd_data[5], 1'b1);
      chk("R5 irq gating", irq, VEC_IRQ[i]);
    end

    // R6 reset pulse, flag clear in window, R10 repeat
    wr(8'h00);
    wr(8'h11);
    rel = 0;
    wait_until(4096 + 100);
    wr(8'h11);
    chk("R4 flag cleared", rd_data[5], 1'b0);
    wait_until(4607);
    chk("R6 no early reset", rst_req, 1'b0);
    wait_until(4608);
    chk("R6 reset pulse", rst_req, 1'b1);
    wait_until(4609);
    chk("R6 single cycle", rst_req, 1'b0);
    wait_until(9215);
    chk("R10 no early repeat", rst_req, 1'b0);
    wait_until(9216);
    chk("R10 repeat pulse", rst_req, 1'b1);

    // R7 restart inside window cancels reset, flag kept
    wr(8'h00);
    wr(8'h11);
    rel = 0;
    wait_until(4096 + 300);
    wr(8'h71);
    rel = 0;
    chk("R7 flag kept", rd_data[5], 1'b1);
    begin
      int seen = 0;
      while (rel < 4607) begin
        wait_until(rel + 1);
        if (rst_req) seen++;
      end
      chk("R7 reset cancelled", seen, 0);
    end
    wait_until(4608);
    chk("R7 next reset from restart", rst_req, 1'b1);

    // R8 interval change restarts the count
    wr(8'h00);
    wr(8'h03);
    rel = 0;
    wait_until(3000);
    wr(8'h01);
    rel = 0;
    wait_until(4095);
    chk("R8 no early flag", rd_data[5], 1'b0);
    wait_until(4096);
    chk("R8 flag after restart", rd_data[5], 1'b1);

    // R9 stopped counter is silent, then full interval on restart
    wr(8'h00);
    wr(8'h01);
    rel = 0;
    wait_until(2000);
    wr(8'h10);
    rel = 0;
    wait_until(5000);
    chk("R9 no flag stopped", rd_data[5], 1'b0);
    chk("R9 no reset stopped", rst_req, 1'b0);
    wr(8'h01);
    rel = 0;
    wait_until(4095);
    chk("R9 full interval", rd_data[5], 1'b0);
    wait_until(4096);
    chk("R9 flag after run", rd_data[5], 1'b1);
    chk("R5 irq off", irq, 1'b0);
    wr(8'h29);
    chk("R5 irq on", irq, 1'b1);

    // R3 longest code does not expire early
    wr(8'h00);
    wr(8'h07);
    rel = 0;
    wait_until(40000);
    chk("R3 code 3 no early flag", rd_data[5], 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule